// File: doc/BRIEF.md
# DS3 Receive Defect Monitor with Change-of-State Interrupts

This block sits behind a DS3 receive framer and turns its per-frame defect flags into a status view and an interrupt. The framer presents, once per frame, a one-cycle end-of-frame strobe together with level flags for alarm indication signal (AIS), loss of signal, out of frame, far-end failure and idle-pattern detection. It also presents pulse flags for C-bit parity error, P-bit parity error and a change of the application identification channel.

AIS, loss of signal, out of frame and far-end failure take the sampled value at each strobe. The idle flag passes through a frame-count hysteresis: the Idle condition is declared only after a run of consecutive idle frames, and it is cleared only after an equally long run of non-idle frames. Every declaration and every clearing is latched as an event. A single active-high interrupt output combines the latched events with a software enable mask. The AIS state also drives a transmit request for the far-end receive failure indication.

A small synchronous register port exposes three registers: defect status, interrupt enable, and latched interrupt events. The latched-event register clears on read.

Top module: `ds3_defect_irq`

## Requirements
- R1: The Idle condition (status bit 5) is declared at the end-of-frame strobe that completes IDLE_FRAMES (default 63) consecutive frames with the idle flag high. A frame without the flag restarts this count, and one frame fewer does not declare.
- R2: The Idle condition is cleared at the strobe that completes IDLE_FRAMES consecutive frames with the idle flag low. An idle frame restarts this count.
- R3: AIS, loss of signal and out of frame are sampled only on the end-of-frame strobe and appear in the status register at address 0x10 as bit 7 (AIS), bit 6 (loss of signal) and bit 4 (out of frame). A change of these inputs without a strobe has no effect.
- R4: tx_ferf_req is high exactly while the sampled AIS state is declared.
- R5: Each level defect (AIS, loss of signal, out of frame, far-end failure, Idle) latches an event when it is declared and also when it is cleared. Each pulse source (C-bit error, P-bit error, identification change) latches an event when it is high at a strobe. The event register at address 0x14 uses this layout: bit 7 C-bit error, 6 loss of signal, 5 AIS, 4 Idle, 3 far-end failure, 2 identification change, 1 out of frame, 0 P-bit error.
- R6: A read of address 0x14 returns the latched events and clears them.
- R7: The interrupt enable register at address 0x12 is read/write, uses the event bit layout and resets to 0. irq is high when any latched event has its enable bit set. A masked event is still latched, and it raises irq as soon as its enable bit is written to 1.
- R8: Status bits 2..0 are read/write configuration bits. Bit 3 reads 0. Writes to bits 7..3 have no effect.
- R9: After a synchronous reset, every register reads 0 and irq and tx_ferf_req are 0. A read of any other address returns 0. Read data appears on rdata on the cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_end | input | 1 | One-cycle end-of-frame strobe |
| idle_seen | input | 1 | Current frame carried the idle pattern |
| ais_in | input | 1 | AIS detected in the current frame |
| los_in | input | 1 | Loss of signal |
| oof_in | input | 1 | Out of frame |
| ferf_in | input | 1 | Far-end failure indication received |
| cp_err | input | 1 | C-bit parity error in the frame |
| p_err | input | 1 | P-bit parity error in the frame |
| aic_chg | input | 1 | Identification channel changed |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Active-high interrupt |
| tx_ferf_req | output | 1 | Request to transmit far-end receive failure |

## Verification
The bench builds the block with its default IDLE_FRAMES of 63. This makes the exact 62-versus-63 frame boundary reachable in both directions of the hysteresis, and a run broken one frame short shows that the count restarts. The default register addresses keep the full map in use, so the bench also confirms that writes to unmapped locations and to the read-only status bits leave every register unchanged. Masked events raising irq later, events on both edges of AIS and Idle, and clear-on-read are each driven through the port alone.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int REG_W = 8;

  // event / enable bit layout
  localparam int EB_CPERR = 7;
  localparam int EB_LOS   = 6;
  localparam int EB_AIS   = 5;
  localparam int EB_IDLE  = 4;
  localparam int EB_FERF  = 3;
  localparam int EB_AIC   = 2;
  localparam int EB_OOF   = 1;
  localparam int EB_PERR  = 0;

  // level defect indices inside the tracker vector
  localparam int LV_AIS  = 0;
  localparam int LV_LOS  = 1;
  localparam int LV_OOF  = 2;
  localparam int LV_FERF = 3;
  localparam int NUM_LVL = 4;

  localparam int CFG_W = 3;

  function automatic logic [REG_W-1:0] pack_status(
    input logic ais, input logic los, input logic idle, input logic oof,
    input logic [CFG_W-1:0] cfg);
    return {ais, los, idle, oof, 1'b0, cfg};
  endfunction
endpackage

// File: rtl/dm_idle_integrator.sv
module dm_idle_integrator #(
  parameter int unsigned IDLE_FRAMES = 63
) (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic idle_seen,
  output logic idle_st,
  output logic idle_chg
);
  localparam int CNT_W = $clog2(IDLE_FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_FRAMES - 1);

  logic [CNT_W-1:0] on_cnt, off_cnt;
  logic             declare, clear;

  always_comb begin
    declare  = sample && idle_seen && !idle_st && (on_cnt == LAST);
    clear    = sample && !idle_seen && idle_st && (off_cnt == LAST);
    idle_chg = declare || clear;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_cnt  <= '0;
      off_cnt <= '0;
      idle_st <= 1'b0;
    end else if (sample) begin
      if (idle_seen) begin
        off_cnt <= '0;
        if (declare) begin
          idle_st <= 1'b1;
          on_cnt  <= '0;
        end else if (!idle_st) begin
          on_cnt <= on_cnt + 1'b1;
        end
      end else begin
        on_cnt <= '0;
        if (clear) begin
          idle_st <= 1'b0;
          off_cnt <= '0;
        end else if (idle_st) begin
          off_cnt <= off_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dm_level_tracker.sv
module dm_level_tracker #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample,
  input  logic [N-1:0] lvl_in,
  output logic [N-1:0] state,
  output logic [N-1:0] chg
);
  for (genvar i = 0; i < N; i++) begin : g_lvl
    assign chg[i] = sample && (lvl_in[i] != state[i]);
    always_ff @(posedge clk) begin
      if (rst)         state[i] <= 1'b0;
      else if (sample) state[i] <= lvl_in[i];
    end
  end
endmodule

// File: rtl/dm_reg_file.sv
module dm_reg_file
  import dm_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int unsigned STAT_ADDR = 'h10,
  parameter int unsigned EN_ADDR   = 'h12,
  parameter int unsigned LAT_ADDR  = 'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [REG_W-1:0]  events,
  input  logic [NUM_LVL-1:0] lvl_state,
  input  logic              idle_st,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);
  localparam logic [ADDR_W-1:0] A_LAT  = ADDR_W'(LAT_ADDR);

  logic [REG_W-1:0] en_q, en_d, lat_q, lat_d, clr, stat_v, rd_mux;
  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    stat_v = pack_status(lvl_state[LV_AIS], lvl_state[LV_LOS], idle_st,
                         lvl_state[LV_OOF], cfg_q);
    unique case (addr)
      A_STAT:  rd_mux = stat_v;
      A_EN:    rd_mux = en_q;
      A_LAT:   rd_mux = lat_q;
      default: rd_mux = '0;
    endcase
    clr   = (rd_en && addr == A_LAT) ? lat_q : '0;
    lat_d = (lat_q & ~clr) | events;
    en_d  = (wr_en && addr == A_EN) ? wdata : en_q;
    cfg_d = (wr_en && addr == A_STAT) ? wdata[CFG_W-1:0] : cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      cfg_q <= '0;
      lat_q <= '0;
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      en_q  <= en_d;
      cfg_q <= cfg_d;
      lat_q <= lat_d;
      irq   <= |(lat_d & en_d);
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ds3_defect_irq.sv
module ds3_defect_irq
  import dm_pkg::*;
#(
  parameter int unsigned IDLE_FRAMES = 63,
  parameter int          ADDR_W      = 8,
  parameter int unsigned STAT_ADDR   = 'h10,
  parameter int unsigned EN_ADDR     = 'h12,
  parameter int unsigned LAT_ADDR    = 'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end,
  input  logic              idle_seen,
  input  logic              ais_in,
  input  logic              los_in,
  input  logic              oof_in,
  input  logic              ferf_in,
  input  logic              cp_err,
  input  logic              p_err,
  input  logic              aic_chg,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq,
  output logic              tx_ferf_req
);
  logic [NUM_LVL-1:0] lvl_in, lvl_state, lvl_chg;
  logic               idle_st, idle_chg;
  logic [REG_W-1:0]   events;

  always_comb begin
    lvl_in          = '0;
    lvl_in[LV_AIS]  = ais_in;
    lvl_in[LV_LOS]  = los_in;
    lvl_in[LV_OOF]  = oof_in;
    lvl_in[LV_FERF] = ferf_in;

    events           = '0;
    events[EB_CPERR] = frame_end && cp_err;
    events[EB_LOS]   = lvl_chg[LV_LOS];
    events[EB_AIS]   = lvl_chg[LV_AIS];
    events[EB_IDLE]  = idle_chg;
    events[EB_FERF]  = lvl_chg[LV_FERF];
    events[EB_AIC]   = frame_end && aic_chg;
    events[EB_OOF]   = lvl_chg[LV_OOF];
    events[EB_PERR]  = frame_end && p_err;
  end

  dm_idle_integrator #(.IDLE_FRAMES(IDLE_FRAMES)) u_idle (
    .clk(clk), .rst(rst), .sample(frame_end), .idle_seen(idle_seen),
    .idle_st(idle_st), .idle_chg(idle_chg)
  );

  dm_level_tracker #(.N(NUM_LVL)) u_lvl (
    .clk(clk), .rst(rst), .sample(frame_end), .lvl_in(lvl_in),
    .state(lvl_state), .chg(lvl_chg)
  );

  dm_reg_file #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR), .LAT_ADDR(LAT_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .events(events), .lvl_state(lvl_state), .idle_st(idle_st),
    .rdata(rdata), .irq(irq)
  );

  assign tx_ferf_req = lvl_state[LV_AIS];
endmodule

// File: rtl/ds3_defect_irq_chk.sv
module ds3_defect_irq_chk (
  input logic clk,
  input logic rst,
  input logic frame_end,
  input logic idle_seen,
  input logic ais_in,
  input logic idle_st,
  input logic tx_ferf_req
);
  AST_FERF_SET:   assert property (@(posedge clk) disable iff (rst)
                    frame_end && ais_in |=> tx_ferf_req);            // R4
  AST_FERF_CLR:   assert property (@(posedge clk) disable iff (rst)
                    frame_end && !ais_in |=> !tx_ferf_req);          // R4
  AST_FERF_HOLD:  assert property (@(posedge clk) disable iff (rst)
                    !frame_end |=> $stable(tx_ferf_req));            // R3
  AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (rst)
                    !frame_end |=> $stable(idle_st));                // R1
  AST_IDLE_RISE:  assert property (@(posedge clk) disable iff (rst)
                    $rose(idle_st) |-> $past(idle_seen));            // R1
  AST_IDLE_FALL:  assert property (@(posedge clk) disable iff (rst)
                    $fell(idle_st) |-> !$past(idle_seen));           // R2
endmodule

bind ds3_defect_irq ds3_defect_irq_chk u_chk (
  .clk(clk), .rst(rst), .frame_end(frame_end), .idle_seen(idle_seen),
  .ais_in(ais_in), .idle_st(idle_st), .tx_ferf_req(tx_ferf_req)
);

// File: tb/ds3_defect_irq_bench.sv
`timescale 1ns/1ps
module ds3_defect_irq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_end = 0, idle_seen = 0, ais_in = 0, los_in = 0, oof_in = 0;
  logic       ferf_in = 0, cp_err = 0, p_err = 0, aic_chg = 0;
  logic       rd_en = 0, wr_en = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic       irq, tx_ferf_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic ais_v = 0, los_v = 0, oof_v = 0, ferf_v = 0, cp_v = 0, p_v = 0, aic_v = 0;

  always #2 clk = ~clk;

  ds3_defect_irq u_ds3_defect_irq (
    .clk(clk), .rst(rst), .frame_end(frame_end), .idle_seen(idle_seen),
    .ais_in(ais_in), .los_in(los_in), .oof_in(oof_in), .ferf_in(ferf_in),
    .cp_err(cp_err), .p_err(p_err), .aic_chg(aic_chg), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
    .tx_ferf_req(tx_ferf_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_frame(input logic idl);
    @(negedge clk);
    frame_end = 1; idle_seen = idl; ais_in = ais_v; los_in = los_v; oof_in = oof_v;
    ferf_in = ferf_v; cp_err = cp_v; p_err = p_v; aic_chg = aic_v;
    @(posedge clk);
    @(negedge clk);
    frame_end = 0;
  endtask

  task automatic frames(input int n, input logic idl);
    for (int i = 0; i < n; i++) do_frame(idl);
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R9 irq after reset", {7'b0, irq}, 8'h00);
    check("R9 ferf after reset", {7'b0, tx_ferf_req}, 8'h00);
    reg_rd(8'h10, d); check("R9 status reset", d, 8'h00);
    reg_rd(8'h12, d); check("R9 enable reset", d, 8'h00);
    reg_rd(8'h14, d); check("R9 events reset", d, 8'h00);
  endtask

  task automatic t_idle();
    logic [7:0] d;
    reg_wr(8'h12, 8'h10);
    frames(40, 1'b1); frames(1, 1'b0); frames(62, 1'b1);
    reg_rd(8'h10, d); check("R1 no idle after broken run + 62", d, 8'h00);
    check("R1 irq still low", {7'b0, irq}, 8'h00);
    frames(1, 1'b1);
    check("R1 irq on idle declare", {7'b0, irq}, 8'h01);
    reg_rd(8'h10, d); check("R1 idle declared at 63", d, 8'h20);
    reg_rd(8'h14, d); check("R5 idle event latched", d, 8'h10);
    check("R6 irq drops after read", {7'b0, irq}, 8'h00);
    reg_rd(8'h14, d); check("R6 events cleared by read", d, 8'h00);
    frames(30, 1'b0); frames(1, 1'b1); frames(62, 1'b0);
    reg_rd(8'h10, d); check("R2 idle held after broken run + 62", d, 8'h20);
    frames(1, 1'b0);
    reg_rd(8'h10, d); check("R2 idle cleared at 63", d, 8'h00);
    reg_rd(8'h14, d); check("R5 idle clear event", d, 8'h10);
  endtask

  task automatic t_ais();
    logic [7:0] d;
    reg_wr(8'h12, 8'h20);
    @(negedge clk); ais_in = 1;
    repeat (3) @(negedge clk);
    check("R3 ais ignored w/o strobe: ferf", {7'b0, tx_ferf_req}, 8'h00);
    reg_rd(8'h10, d); check("R3 ais ignored w/o strobe: status", d, 8'h00);
    ais_v = 1; do_frame(1'b0);
    check("R4 ferf follows ais declare", {7'b0, tx_ferf_req}, 8'h01);
    check("R7 irq on ais", {7'b0, irq}, 8'h01);
    reg_rd(8'h10, d); check("R3 ais in status bit 7", d, 8'h80);
    reg_rd(8'h14, d); check("R5 ais declare event", d, 8'h20);
    ais_v = 0; do_frame(1'b0);
    check("R4 ferf drops with ais", {7'b0, tx_ferf_req}, 8'h00);
    reg_rd(8'h14, d); check("R5 ais clear event", d, 8'h20);
  endtask

  task automatic t_masked();
    logic [7:0] d;
    reg_wr(8'h12, 8'h00);
    los_v = 1; do_frame(1'b0);
    check("R7 masked los no irq", {7'b0, irq}, 8'h00);
    reg_rd(8'h14, d); check("R7 masked los still latched", d, 8'h40);
    oof_v = 1; do_frame(1'b0);
    check("R7 masked oof no irq", {7'b0, irq}, 8'h00);
    reg_wr(8'h12, 8'h02);
    check("R7 enabling pending event raises irq", {7'b0, irq}, 8'h01);
    reg_rd(8'h14, d); check("R5 oof event bit 1", d, 8'h02);
    check("R6 irq cleared by read", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_pulses();
    logic [7:0] d;
    reg_wr(8'h12, 8'hFF);
    cp_v = 1; p_v = 1; aic_v = 1; ferf_v = 1; do_frame(1'b0);
    cp_v = 0; p_v = 0; aic_v = 0;
    check("R7 irq on pulse events", {7'b0, irq}, 8'h01);
    reg_rd(8'h14, d); check("R5 pulse + ferf events", d, 8'h8D);
    do_frame(1'b0);
    reg_rd(8'h14, d); check("R5 no event when levels steady", d, 8'h00);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    reg_wr(8'h10, 8'hFF);
    reg_rd(8'h10, d); check("R8 cfg bits writable, upper ignored", d, 8'h57);
    reg_wr(8'h10, 8'h02);
    reg_rd(8'h10, d); check("R8 cfg rewrite", d, 8'h52);
    reg_wr(8'h11, 8'hAA);
    reg_rd(8'h11, d); check("R9 unmapped reads 0", d, 8'h00);
    reg_rd(8'h12, d); check("R7 enable readback", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_idle();
    t_ais();
    t_masked();
    t_pulses();
    t_cfg();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule